// File: doc/BRIEF.md
# Interrupt Acceptance Sequencer

This block models how a small CPU core takes an interrupt. Once a request is accepted, it waits until the core reports that the current instruction has finished. It then runs a timed acceptance sequence with an internal down-counter. In the last cycle of that sequence it pulses a done signal, which marks the first handler instruction. It also updates the processor's interrupt priority level.

The length of the sequence depends on the parity of two values sampled when the request is accepted: the handler's vector address and the stack pointer. Some debug-type sources add cycles to that length. How the priority level is updated depends on the class of the source. A maskable request takes its own level. An urgent system event raises the level to the maximum. Software and debug traps leave the level as it is.

Source codes on `irq_src`:
- 0: maskable
- 1: urgent system event (watchdog, NMI, oscillator stop, low voltage)
- 2: software trap
- 3: address match
- 4: single-step
- 5: debug break
- 6 and 7: behave as a software trap

Top module: `irq_accept_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the level is cleared to 0, the block becomes idle, and both `busy` and `seq_done` are low from the next cycle.
- R2: In the idle state, a request with `irq_src`=0 is accepted only when `irq_lvl` is strictly greater than the current `ipl`; otherwise it is ignored and `busy` stays low. Requests with any other code are always accepted.
- R3: `busy` rises in the cycle after acceptance and stays high through the done cycle. While idle, a pulse on `insn_done` has no effect.
- R4: Let N be 18, plus 1 if `vec_addr[0]` is 1, plus 1 if `sp_val[0]` is 1, both sampled at acceptance. `seq_done` goes high in the Nth cycle after the cycle in which `insn_done` is seen high while the block waits.
- R5: Source code 5 adds 2 cycles to N. Codes 3 and 4 add 1 cycle. All other codes add nothing.
- R6: For `irq_src`=0, `ipl` becomes the accepted `irq_lvl`.
- R7: For `irq_src`=1, `ipl` becomes 7.
- R8: For `irq_src` from 2 to 7, `ipl` keeps its value.
- R9: `ipl` shows the new level in the same cycle as `seq_done`, and does not change in any other cycle.
- R10: `seq_done` lasts exactly one cycle. Requests presented while busy, including in the done cycle, are ignored. `busy` is low in the cycle after `seq_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | 1 | Interrupt request present |
| irq_src | input | 3 | Source code of the request |
| irq_lvl | input | 3 | Priority of a maskable request |
| sp_val | input | 16 | Current stack pointer |
| vec_addr | input | 20 | Handler vector address |
| insn_done | input | 1 | Strobe: the executing instruction has completed |
| busy | output | 1 | Acceptance in progress |
| seq_done | output | 1 | One-cycle pulse in the last sequence cycle |
| ipl | output | 3 | Current interrupt priority level |

## Verification
The assertions check several rules on every cycle:
- the done pulse is one cycle wide and only occurs while busy;
- the level changes only at done;
- the maskable, urgent and software rules for the level hold;
- an internal cycle count agrees with the latched length.

Only the bench scenarios can show the rest. They check that the length comes from the right parity bits and source extras, and that the count starts at the completion strobe after waits of 1 to 30 cycles. They also check that requests below or equal to the current level are refused, and that requests presented while busy leave no trace.

// File: rtl/irq_accept_seq.sv
module irq_accept_seq #(
  parameter int VEC_W    = 20,
  parameter int SP_W     = 16,
  parameter int IPL_W    = 3,
  parameter int BASE_CYC = 18,
  parameter int CNT_W    = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             irq_req,
  input  logic [2:0]       irq_src,
  input  logic [IPL_W-1:0] irq_lvl,
  input  logic [SP_W-1:0]  sp_val,
  input  logic [VEC_W-1:0] vec_addr,
  input  logic             insn_done,
  output logic             busy,
  output logic             seq_done,
  output logic [IPL_W-1:0] ipl
);

  localparam logic [IPL_W-1:0] IPL_TOP = '1;
  localparam logic [2:0] SRC_MASK = 3'd0, SRC_URG = 3'd1;

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_RUN} st_t;

  st_t              st_q;
  logic [CNT_W-1:0] cnt_q, len_q, len_in, extra;
  logic [2:0]       src_q;
  logic [IPL_W-1:0] lvl_q, ipl_q, ipl_next;
  logic             accept;

  wire unused_hi = ^{sp_val[SP_W-1:1], vec_addr[VEC_W-1:1]};

  assign accept = (st_q == S_IDLE) && irq_req &&
                  ((irq_src != SRC_MASK) || (irq_lvl > ipl_q));

  always_comb
    case (irq_src)
      3'd3, 3'd4: extra = CNT_W'(1);
      3'd5:       extra = CNT_W'(2);
      default:    extra = '0;
    endcase

  assign len_in = CNT_W'(BASE_CYC) + CNT_W'(vec_addr[0]) + CNT_W'(sp_val[0]) + extra;

  always_comb
    case (src_q)
      SRC_MASK: ipl_next = lvl_q;
      SRC_URG:  ipl_next = IPL_TOP;
      default:  ipl_next = ipl_q;
    endcase

  assign busy     = st_q != S_IDLE;
  assign seq_done = (st_q == S_RUN) && (cnt_q == '0);
  assign ipl      = seq_done ? ipl_next : ipl_q;

  always_ff @(posedge clk)
    if (rst) begin
      st_q  <= S_IDLE;
      cnt_q <= '0;
      len_q <= '0;
      src_q <= '0;
      lvl_q <= '0;
      ipl_q <= '0;
    end else
      case (st_q)
        S_IDLE: if (accept) begin
          st_q  <= S_WAIT;
          src_q <= irq_src;
          lvl_q <= irq_lvl;
          len_q <= len_in;
        end
        S_WAIT: if (insn_done) begin
          st_q  <= S_RUN;
          cnt_q <= len_q - CNT_W'(1);
        end
        S_RUN: if (cnt_q == '0) begin
          st_q  <= S_IDLE;
          ipl_q <= ipl_next;
        end else
          cnt_q <= cnt_q - CNT_W'(1);
        default: st_q <= S_IDLE;
      endcase

  logic [CNT_W-1:0] run_len;
  always_ff @(posedge clk)
    if (rst || st_q != S_RUN) run_len <= CNT_W'(1);
    else                      run_len <= run_len + CNT_W'(1);

  p_reset_idle_r1: assert property (@(posedge clk) rst |=> !busy && !seq_done && ipl == '0);
  p_refuse_low_r2: assert property (@(posedge clk) disable iff (rst)
    (st_q == S_IDLE && irq_req && irq_src == SRC_MASK && irq_lvl <= ipl) |=> !busy);
  p_busy_hold_r3: assert property (@(posedge clk) disable iff (rst) (busy && !seq_done) |=> busy);
  p_idle_strobe_r3: assert property (@(posedge clk) disable iff (rst) (!busy && !irq_req) |=> !busy);
  p_len_match_r4: assert property (@(posedge clk) disable iff (rst) seq_done |-> run_len == len_q);
  p_mask_lvl_r6: assert property (@(posedge clk) disable iff (rst)
    (seq_done && src_q == SRC_MASK) |-> (ipl == lvl_q && ipl > ipl_q));
  p_urgent_top_r7: assert property (@(posedge clk) disable iff (rst) (seq_done && src_q == SRC_URG) |-> ipl == IPL_TOP);
  p_soft_keep_r8: assert property (@(posedge clk) disable iff (rst) (seq_done && src_q > SRC_URG) |-> ipl == ipl_q);
  p_ipl_hold_r9: assert property (@(posedge clk) (!rst && !seq_done) |=> $stable(ipl_q));
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst) seq_done |=> (!seq_done && !busy));
  p_done_busy_r10: assert property (@(posedge clk) disable iff (rst) seq_done |-> busy);

endmodule

// File: tb/test_irq_accept_seq.sv
`timescale 1ns/1ps
module test_irq_accept_seq;
  logic clk = 0, rst = 1;
  logic irq_req = 0, insn_done = 0;
  logic [2:0] irq_src = 0, irq_lvl = 0;
  logic [15:0] sp_val = 0;
  logic [19:0] vec_addr = 0;
  logic busy, seq_done;
  logic [2:0] ipl;
  int checks = 0, fails = 0;
  logic [2:0] ipl_m = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  irq_accept_seq i_irq_accept_seq (.clk, .rst, .irq_req, .irq_src, .irq_lvl, .sp_val,
    .vec_addr, .insn_done, .busy, .seq_done, .ipl);

  function automatic int exp_len(input logic [2:0] s, input logic v0, input logic s0);
    int n = 18 + int'(v0) + int'(s0);
    if (s == 3'd5) n += 2;
    else if (s == 3'd3 || s == 3'd4) n += 1;
    return n;
  endfunction

  function automatic logic [2:0] exp_ipl(input logic [2:0] s, input logic [2:0] l, input logic [2:0] cur);
    if (s == 3'd0) return l;
    if (s == 3'd1) return 3'd7;
    return cur;
  endfunction

  function automatic bit exp_acc(input logic [2:0] s, input logic [2:0] l, input logic [2:0] cur);
    return (s != 3'd0) || (l > cur);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic run_irq(input logic [2:0] s, input logic [2:0] l, input logic [19:0] v,
                         input logic [15:0] sp, input int dly);
    bit acc = exp_acc(s, l, ipl_m);
    int n = exp_len(s, v[0], sp[0]);
    logic [2:0] nxt = exp_ipl(s, l, ipl_m);
    @(negedge clk);
    irq_req = 1; irq_src = s; irq_lvl = l; vec_addr = v; sp_val = sp;
    @(negedge clk);
    irq_req = 0;
    chk("R2 acceptance", busy, acc);
    if (!acc) begin
      chk("R2 refused keeps level", ipl, ipl_m);
      return;
    end
    for (int k = 1; k < dly; k++) begin
      if (k == 2) begin
        irq_req = 1; irq_src = 3'd1; vec_addr = ~v; sp_val = ~sp;
      end else irq_req = 0;
      @(negedge clk);
      chk("R3 waiting busy", busy, 1);
      chk("R3 no early done", seq_done, 0);
    end
    irq_req = 0;
    insn_done = 1;
    @(negedge clk);
    insn_done = 0;
    for (int k = 1; k <= n; k++) begin
      chk((s >= 3 && s <= 5) ? "R5 length with extra" : "R4 length", seq_done, k == n);
      if (k == n) begin
        chk(s == 0 ? "R6 maskable level" : s == 1 ? "R7 urgent level" : "R8 level kept", ipl, nxt);
        chk("R9 level at done", ipl, nxt);
        irq_req = 1; irq_src = 3'd1;
      end else if (k == 1) chk("R9 level held", ipl, ipl_m);
      @(negedge clk);
    end
    irq_req = 0;
    ipl_m = nxt;
    chk("R10 busy drops", busy, 0);
    chk("R10 single pulse", seq_done, 0);
    chk("R10 level after done", ipl, ipl_m);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 reset level", ipl, 0);
    chk("R1 reset busy", busy, 0);
    chk("R1 reset done", seq_done, 0);
    insn_done = 1; @(negedge clk); insn_done = 0; @(negedge clk);
    chk("R3 idle strobe ignored", busy, 0);
    run_irq(3'd0, 3'd0, 20'h00100, 16'h0200, 3);
    run_irq(3'd0, 3'd3, 20'h00100, 16'h0200, 1);
    run_irq(3'd0, 3'd3, 20'h00101, 16'h0200, 5);
    run_irq(3'd0, 3'd2, 20'h00100, 16'h0200, 5);
    run_irq(3'd2, 3'd0, 20'h00100, 16'h0201, 30);
    run_irq(3'd3, 3'd0, 20'h00101, 16'h0201, 2);
    run_irq(3'd4, 3'd0, 20'h00100, 16'h0200, 7);
    run_irq(3'd5, 3'd0, 20'h00101, 16'h0201, 4);
    run_irq(3'd1, 3'd0, 20'h00100, 16'h0200, 1);
    run_irq(3'd0, 3'd7, 20'h00100, 16'h0200, 2);
    for (int i = 0; i < 80; i++) begin
      if (i % 16 == 0) begin
        rst = 1; @(negedge clk); rst = 0; ipl_m = 0;
        chk("R1 reset mid-run", ipl, 0);
      end
      run_irq(3'($urandom_range(0, 7)), 3'($urandom_range(0, 7)), 20'($urandom),
              16'($urandom), $urandom_range(1, 30));
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule